// File: doc/BRIEF.md
# I2C Master Byte-Transfer Engine

This block is the protocol engine of an I2C bus master. It moves one byte for each software command. Software presents a byte and three framing bits (start, stop, acknowledge-select), then pulses a transfer-go request. The engine frames that single byte on the open-drain SCL/SDA pair. It adds a START or repeated START in front of the byte when asked, handles the ninth-bit acknowledge, and ends with a STOP when asked. Otherwise it leaves the bus held with SCL low so that the next byte, or a new address, can follow.

Progress is reported through sticky event flags that software clears by writing 1. A transmit-empty flag marks a sent byte, including the address byte. A receive-full flag marks a received byte. Level bits show bus ownership, the direction taken from the last address byte, the acknowledge the master sent, and whether a slave refused a byte. An interrupt line is the OR of the two event flags. SCL runs at the system clock divided by four times the `QUARTER_CYCLES` parameter. Each bit is split into four equal phases, and SDA moves only in the SCL-low phases, except for START and STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both line drivers are released (`scl_drive_lo`=0, `sda_drive_lo`=0), and `go_bit`, `st_te`, `st_rf`, `st_busy`, `st_rw`, `st_acknak`, `st_nakrx` and `irq` are all 0.
- R2: A go request with `ctl_start`=1 sends a START, then `tx_byte` MSB first as an address byte. `st_rw` takes bit 0 of that byte (1 = read), and `st_busy` is 1 from the START until the matching STOP ends.
- R3: When a transmitted byte (address or data) finishes its ninth clock, `st_te` and `irq` become 1 and `go_bit` returns to 0 at the same clock edge.
- R4: `st_te` and `st_rf` stay set until a 1 is written to them (`clr_te`/`clr_rf` pulse), and `irq` is 1 exactly while either is set.
- R5: With `ctl_stop`=1 the byte is followed by a STOP and `st_busy` falls to 0. With `ctl_stop`=0 the engine holds SCL low and keeps `st_busy`=1 until the next go request.
- R6: After an address byte with bit 0 = 1, a go request without start receives one byte MSB first into `rx_byte`, sets `st_rf` (not `st_te`), and sends the ninth bit from `ctl_acksel`: 0 drives ACK (SDA low), 1 leaves NAK (SDA high). `st_acknak` shows that value.
- R7: A go request with `ctl_start`=1 while the bus is held produces a repeated START and a new address byte, without a STOP in between.
- R8: After each transmitted byte, `st_nakrx` shows the slave's ninth bit as sampled with SCL high: 1 for NAK, 0 for ACK.
- R9: SDA changes only while SCL is low, except for the SDA fall that forms a START and the SDA rise that forms a STOP.
- R10: A go request that arrives while a byte is in flight (`go_bit`=1) has no effect: exactly one byte is framed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_wr | input | 1 | Pulse: request one byte transfer |
| ctl_start | input | 1 | Send START / repeated START before the byte |
| ctl_stop | input | 1 | Send STOP after the byte |
| ctl_acksel | input | 1 | Receive response: 0 = ACK, 1 = NAK |
| tx_byte | input | 8 | Byte to send (address byte when start is set) |
| clr_te | input | 1 | Write-1 clear of the transmit-empty flag |
| clr_rf | input | 1 | Write-1 clear of the receive-full flag |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_drive_lo | output | 1 | Pull SCL low when 1 |
| sda_drive_lo | output | 1 | Pull SDA low when 1 |
| go_bit | output | 1 | Transfer-go bit, self-clearing |
| rx_byte | output | 8 | Last received byte |
| st_te | output | 1 | Transmit-empty event flag |
| st_rf | output | 1 | Receive-full event flag |
| st_busy | output | 1 | Master owns the bus |
| st_rw | output | 1 | Direction bit of the last address byte |
| st_acknak | output | 1 | Acknowledge sent after the last received byte |
| st_nakrx | output | 1 | Slave returned NAK on the last sent byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that no other device pulls SCL and that the framing inputs are steady in the cycle the go request is taken. The line-timing property also assumes that only this master's driver is judged, not a slave's pull on SDA. The bench honours these rules. It changes `ctl_start`, `ctl_stop`, `ctl_acksel` and `tx_byte` only together with the go pulse. Its behavioural slave moves SDA only on SCL falling edges and never touches SCL. Clear pulses are issued only after a completion has been observed.

// File: rtl/i2c_bm_pkg.sv
`timescale 1ns/1ps
package i2c_bm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_BIT,
      ST_STOP,
      ST_HOLD
   } seq_state_e;

   // one record per finished byte, handed from sequencer to status
   typedef struct packed {
      logic       valid;
      logic       was_tx;
      logic       nak_seen;
      logic       ack_sent;
      logic [7:0] data;
   } byte_evt_t;

endpackage

// File: rtl/i2c_bm_qtick.sv
`timescale 1ns/1ps
module i2c_bm_qtick #(
   parameter int QUARTER_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(QUARTER_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run)         cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/i2c_bm_sync.sv
`timescale 1ns/1ps
module i2c_bm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '1;
            else begin
               ff_q[0] <= d;
               for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
            end
         end
         assign q = ff_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_bm_seq.sv
`timescale 1ns/1ps
module i2c_bm_seq
   import i2c_bm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      go_wr,
   input  logic      ctl_start,
   input  logic      ctl_stop,
   input  logic      ctl_acksel,
   input  logic [7:0] tx_byte,
   input  logic      sda_s,
   input  logic      tick,
   output logic      run,
   output logic      scl_lo_q,
   output logic      sda_lo_q,
   output logic      go_q,
   output logic      busy,
   output logic      rw_q,
   output byte_evt_t evt
);
   seq_state_e st_q;
   logic [1:0] ph_q;
   logic [3:0] bitn_q;
   logic [7:0] sh_q;
   logic       tx_dir_q, stop_l_q, ack_l_q, ack_in_q;
   logic       free_q;
   logic       launch, done;
   logic       scl_n, sda_n;

   assign launch = go_q && (st_q == ST_IDLE || st_q == ST_HOLD);
   assign done   = (st_q == ST_BIT) && tick && (ph_q == 2'd3) && (bitn_q == 4'd8);
   assign run    = (st_q == ST_START) || (st_q == ST_BIT) || (st_q == ST_STOP);
   assign busy   = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         ph_q     <= '0;
         bitn_q   <= '0;
         sh_q     <= '0;
         tx_dir_q <= 1'b1;
         stop_l_q <= 1'b0;
         ack_l_q  <= 1'b0;
         ack_in_q <= 1'b0;
         rw_q     <= 1'b0;
      end else if (launch) begin
         sh_q     <= tx_byte;
         stop_l_q <= ctl_stop;
         ack_l_q  <= ctl_acksel;
         ph_q     <= '0;
         bitn_q   <= '0;
         if (ctl_start || st_q == ST_IDLE) begin
            st_q     <= ST_START;
            tx_dir_q <= 1'b1;
            rw_q     <= tx_byte[0];
         end else begin
            st_q     <= ST_BIT;
            tx_dir_q <= ~rw_q;
         end
      end else if (tick) begin
         ph_q <= ph_q + 2'd1;
         case (st_q)
            ST_START: if (ph_q == 2'd3) st_q <= ST_BIT;
            ST_BIT: begin
               if (ph_q == 2'd2) begin
                  if (bitn_q == 4'd8)  ack_in_q <= sda_s;
                  else if (!tx_dir_q)  sh_q <= {sh_q[6:0], sda_s};
               end
               if (ph_q == 2'd3) begin
                  if (bitn_q == 4'd8) begin
                     bitn_q <= '0;
                     st_q   <= stop_l_q ? ST_STOP : ST_HOLD;
                  end else begin
                     bitn_q <= bitn_q + 4'd1;
                     if (tx_dir_q) sh_q <= {sh_q[6:0], 1'b0};
                  end
               end
            end
            ST_STOP: if (ph_q == 2'd3) st_q <= ST_IDLE;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     go_q <= 1'b0;
      else if (done)  go_q <= 1'b0;
      else if (go_wr) go_q <= 1'b1;
   end

   // line pattern per phase; SCL high in phases 1 and 2 of a bit
   always_comb begin
      scl_n = 1'b0;
      sda_n = 1'b0;
      case (st_q)
         ST_START: begin
            scl_n = (ph_q == 2'd0) || (ph_q == 2'd3);
            sda_n = ph_q[1];
         end
         ST_BIT: begin
            scl_n = (ph_q == 2'd0) || (ph_q == 2'd3);
            if (bitn_q == 4'd8) sda_n = tx_dir_q ? 1'b0 : ~ack_l_q;
            else                sda_n = tx_dir_q ? ~sh_q[7] : 1'b0;
         end
         ST_STOP: begin
            scl_n = (ph_q == 2'd0);
            sda_n = ~ph_q[1];
         end
         ST_HOLD: scl_n = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_lo_q <= 1'b0;
         sda_lo_q <= 1'b0;
         free_q   <= 1'b0;
      end else begin
         scl_lo_q <= scl_n;
         sda_lo_q <= sda_n;
         free_q   <= (st_q == ST_START) || (st_q == ST_STOP);
      end
   end

   assign evt.valid    = done;
   assign evt.was_tx   = tx_dir_q;
   assign evt.nak_seen = ack_in_q;
   assign evt.ack_sent = ack_l_q;
   assign evt.data     = sh_q;

   // R9: outside START/STOP framing, SDA moves only with SCL held low
   p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_lo_q != $past(sda_lo_q)) && !free_q && !$past(free_q)
      |-> scl_lo_q && $past(scl_lo_q));

   // R3: the go bit is gone the cycle after a byte completes
   p_go_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !go_q);

   // R5: a held bus keeps SCL low
   p_hold_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD) && ($past(st_q) == ST_HOLD) |-> scl_lo_q);

   // R1: an idle engine releases both lines
   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) && ($past(st_q) == ST_IDLE) |-> !scl_lo_q && !sda_lo_q);
endmodule

// File: rtl/i2c_bm_status.sv
`timescale 1ns/1ps
module i2c_bm_status
   import i2c_bm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  byte_evt_t  evt,
   input  logic       clr_te,
   input  logic       clr_rf,
   output logic       te_q,
   output logic       rf_q,
   output logic       acknak_q,
   output logic       nakrx_q,
   output logic [7:0] rx_q,
   output logic       irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         te_q     <= 1'b0;
         rf_q     <= 1'b0;
         acknak_q <= 1'b0;
         nakrx_q  <= 1'b0;
         rx_q     <= '0;
      end else begin
         if (evt.valid && evt.was_tx) begin
            te_q    <= 1'b1;
            nakrx_q <= evt.nak_seen;
         end else if (clr_te) begin
            te_q <= 1'b0;
         end
         if (evt.valid && !evt.was_tx) begin
            rf_q     <= 1'b1;
            rx_q     <= evt.data;
            acknak_q <= evt.ack_sent;
         end else if (clr_rf) begin
            rf_q <= 1'b0;
         end
      end
   end

   assign irq = te_q | rf_q;

   p_te_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      te_q && !clr_te |=> te_q);

   p_rf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_q && !clr_rf |=> rf_q);

   // R6: every finished byte raises one of the two event flags
   p_evt_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt.valid |=> (te_q || rf_q));
endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master
   import i2c_bm_pkg::*;
#(
   parameter int QUARTER_CYCLES = 4,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_wr,
   input  logic       ctl_start,
   input  logic       ctl_stop,
   input  logic       ctl_acksel,
   input  logic [7:0] tx_byte,
   input  logic       clr_te,
   input  logic       clr_rf,
   input  logic       sda_in,
   output logic       scl_drive_lo,
   output logic       sda_drive_lo,
   output logic       go_bit,
   output logic [7:0] rx_byte,
   output logic       st_te,
   output logic       st_rf,
   output logic       st_busy,
   output logic       st_rw,
   output logic       st_acknak,
   output logic       st_nakrx,
   output logic       irq
);
   generate
      if (QUARTER_CYCLES < 2) begin : g_bad_quarter
         $error("QUARTER_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES >= QUARTER_CYCLES) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0 .. QUARTER_CYCLES-1");
      end
   endgenerate

   logic      sda_s, tick, run;
   byte_evt_t evt;

   i2c_bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (sda_in), .q (sda_s)
   );

   i2c_bm_qtick #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_qtick (
      .clk (clk), .rst_n (rst_n), .run (run), .tick (tick)
   );

   i2c_bm_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_wr      (go_wr),
      .ctl_start  (ctl_start),
      .ctl_stop   (ctl_stop),
      .ctl_acksel (ctl_acksel),
      .tx_byte    (tx_byte),
      .sda_s      (sda_s),
      .tick       (tick),
      .run        (run),
      .scl_lo_q   (scl_drive_lo),
      .sda_lo_q   (sda_drive_lo),
      .go_q       (go_bit),
      .busy       (st_busy),
      .rw_q       (st_rw),
      .evt        (evt)
   );

   i2c_bm_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .clr_te   (clr_te),
      .clr_rf   (clr_rf),
      .te_q     (st_te),
      .rf_q     (st_rf),
      .acknak_q (st_acknak),
      .nakrx_q  (st_nakrx),
      .rx_q     (rx_byte),
      .irq      (irq)
   );
endmodule

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go_wr = 1'b0, ctl_start = 1'b0, ctl_stop = 1'b0, ctl_acksel = 1'b0;
   logic [7:0] tx_byte = '0;
   logic clr_te = 1'b0, clr_rf = 1'b0;
   logic scl_drive_lo, sda_drive_lo, go_bit, st_te, st_rf, st_busy, st_rw;
   logic st_acknak, st_nakrx, irq;
   logic [7:0] rx_byte;

   logic slv_lo = 1'b0;
   logic scl_bus, sda_bus;
   assign scl_bus = ~scl_drive_lo;
   assign sda_bus = ~(sda_drive_lo | slv_lo);

   always #2 clk = ~clk;

   i2c_byte_master #(.QUARTER_CYCLES(4), .SYNC_STAGES(2)) dut_i (
      .clk (clk), .rst_n (rst_n), .go_wr (go_wr), .ctl_start (ctl_start),
      .ctl_stop (ctl_stop), .ctl_acksel (ctl_acksel), .tx_byte (tx_byte),
      .clr_te (clr_te), .clr_rf (clr_rf), .sda_in (sda_bus),
      .scl_drive_lo (scl_drive_lo), .sda_drive_lo (sda_drive_lo),
      .go_bit (go_bit), .rx_byte (rx_byte), .st_te (st_te), .st_rf (st_rf),
      .st_busy (st_busy), .st_rw (st_rw), .st_acknak (st_acknak),
      .st_nakrx (st_nakrx), .irq (irq)
   );

   // ---------------- behavioural slave at address 7'h2A ----------------
   localparam logic [6:0] SLV_ADDR = 7'h2A;
   int         mode = 0;          // 0 none, 1 address, 2 write data, 3 read data
   int         bcnt = 0;
   logic [7:0] sr = '0, rdb = '0, rd_next = 8'hC0;
   logic       matched = 1'b0, mack = 1'b0;
   logic [7:0] wlog [0:7];
   int         wn = 0, n_start = 0, n_stop = 0;

   always @(negedge sda_bus) if (scl_bus === 1'b1) begin
      mode = 1; bcnt = -1; slv_lo = 1'b0; n_start++;
   end
   always @(posedge sda_bus) if (scl_bus === 1'b1 && rst_n) begin
      mode = 0; n_stop++;
   end
   always @(posedge scl_bus) if (mode != 0) begin
      if (bcnt >= 0 && bcnt < 8 && mode != 3) sr = {sr[6:0], sda_bus};
      if (mode == 3 && bcnt == 8) mack = sda_bus;
   end
   always @(negedge scl_bus) if (mode != 0) begin
      bcnt++;
      if (bcnt == 8) begin
         if (mode == 1) begin matched = (sr[7:1] == SLV_ADDR); slv_lo = matched; end
         else if (mode == 2) begin slv_lo = 1'b1; wlog[wn[2:0]] = sr; wn++; end
         else slv_lo = 1'b0;
      end else if (bcnt == 9) begin
         bcnt = 0; slv_lo = 1'b0;
         if (mode == 1) mode = matched ? (sr[0] ? 3 : 2) : 0;
         else if (mode == 3 && mack) mode = 0;
         if (mode == 3) begin rdb = rd_next; rd_next = rd_next + 8'd1; slv_lo = ~rdb[7]; end
      end else if (mode == 3 && bcnt < 8) begin
         slv_lo = ~rdb[7 - bcnt];
      end
   end

   // ---------------- checking helpers ----------------
   int n_chk = 0, n_bad = 0;
   bit done_flag = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_go_clear(input string tag);
      int n = 0;
      while (go_bit && n < 5000) begin @(negedge clk); n++; end
      if (n >= 5000) chk({tag, " go timeout"}, 1, 0);
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (st_busy && n < 5000) begin @(negedge clk); n++; end
      if (n >= 5000) chk({tag, " idle timeout"}, 1, 0);
   endtask

   task automatic xfer(input logic s, input logic p, input logic a,
                       input logic [7:0] d, input bit extra_go);
      @(negedge clk);
      ctl_start = s; ctl_stop = p; ctl_acksel = a; tx_byte = d; go_wr = 1'b1;
      @(negedge clk);
      go_wr = 1'b0;
      if (extra_go) begin
         repeat (30) @(negedge clk);
         go_wr = 1'b1;
         @(negedge clk);
         go_wr = 1'b0;
      end
      wait_go_clear("xfer");
   endtask

   task automatic clear_te();
      @(negedge clk); clr_te = 1'b1;
      @(negedge clk); clr_te = 1'b0;
   endtask

   task automatic clear_rf();
      @(negedge clk); clr_rf = 1'b1;
      @(negedge clk); clr_rf = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1 scl_drive_lo", scl_drive_lo, 0);
      chk("R1 sda_drive_lo", sda_drive_lo, 0);
      chk("R1 go_bit", go_bit, 0);
      chk("R1 flags", {st_te, st_rf, st_busy, st_rw, st_acknak, st_nakrx}, 0);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_write();
      xfer(1, 0, 0, 8'h54, 0);
      chk("R3 te after address", st_te, 1);
      chk("R3 irq after address", irq, 1);
      chk("R3 go self-cleared", go_bit, 0);
      chk("R2 rw write", st_rw, 0);
      chk("R2 busy", st_busy, 1);
      chk("R8 address acked", st_nakrx, 0);
      repeat (20) @(negedge clk);
      chk("R4 te sticky", st_te, 1);
      clear_te();
      chk("R4 te cleared", st_te, 0);
      chk("R4 irq low", irq, 0);
      xfer(0, 0, 0, 8'hA5, 0);
      chk("R3 te after data", st_te, 1);
      repeat (50) @(negedge clk);
      chk("R5 scl held low", scl_drive_lo, 1);
      chk("R5 busy held", st_busy, 1);
      clear_te();
      xfer(0, 1, 0, 8'h3C, 1);
      wait_idle("write stop");
      repeat (4) @(negedge clk);
      chk("R5 busy after stop", st_busy, 0);
      chk("R5 lines released", {scl_drive_lo, sda_drive_lo}, 0);
      chk("R10 go stays clear", go_bit, 0);
      chk("R10 slave byte count", wn, 2);
      chk("R2 slave byte0", wlog[0], 8'hA5);
      chk("R2 slave byte1", wlog[1], 8'h3C);
      clear_te();
   endtask

   task automatic t_nak();
      xfer(1, 1, 0, 8'h20, 0);
      chk("R8 nak seen", st_nakrx, 1);
      chk("R3 te on nak", st_te, 1);
      wait_idle("nak stop");
      chk("R5 idle after nak", st_busy, 0);
      clear_te();
   endtask

   task automatic t_read2();
      xfer(1, 0, 0, 8'h55, 0);
      chk("R2 rw read", st_rw, 1);
      chk("R8 read address acked", st_nakrx, 0);
      clear_te();
      xfer(0, 0, 0, 8'h00, 0);
      chk("R6 rf set", st_rf, 1);
      chk("R6 te not set", st_te, 0);
      chk("R6 first byte", rx_byte, 8'hC0);
      chk("R6 acknak ack", st_acknak, 0);
      chk("R6 slave saw ack", mack, 0);
      chk("R4 irq with rf", irq, 1);
      clear_rf();
      chk("R4 rf cleared", st_rf, 0);
      xfer(0, 1, 1, 8'h00, 0);
      chk("R6 second byte", rx_byte, 8'hC1);
      chk("R6 acknak nak", st_acknak, 1);
      wait_idle("read stop");
      chk("R6 slave saw nak", mack, 1);
      chk("R5 idle after read", st_busy, 0);
      clear_rf();
   endtask

   task automatic t_repstart();
      int wn0;
      wn0 = wn;
      xfer(1, 0, 0, 8'h54, 0);
      clear_te();
      xfer(0, 0, 0, 8'h77, 0);
      clear_te();
      chk("R7 write before restart", wlog[wn0[2:0]], 8'h77);
      xfer(1, 0, 0, 8'h55, 0);
      chk("R7 rw after restart", st_rw, 1);
      chk("R7 busy kept", st_busy, 1);
      chk("R7 restart address acked", st_nakrx, 0);
      clear_te();
      xfer(0, 1, 1, 8'h00, 0);
      chk("R7 byte after restart", rx_byte, 8'hC2);
      wait_idle("restart stop");
      clear_rf();
   endtask

   task automatic t_conditions();
      chk("R9 START count", n_start, 5);
      chk("R9 STOP count", n_stop, 4);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_nak();
      t_read2();
      t_repstart();
      t_conditions();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end (expected completion)");
      finish_run();
   end
endmodule